// File: doc/BRIEF.md
# Set-Associative Translation Cache

This block keeps a small number of recently used page table entries close to the address translation logic. It maps a virtual page number to a physical page number and a set of access-permission flags. When the entry is already held, the translation is returned without a trip to memory. When it is not held, the block reports a miss. External logic then fetches the entry, and a fill port installs it.

The set is chosen by the lowest bits of the virtual page number. The remaining upper bits form the tag that is stored beside each line. Every line holds a valid flag, the tag, the physical page number and four permission flags. When a set is full, a fill chooses its victim with a round-robin pointer that each set keeps for itself. A single invalidate-all input empties the whole structure in one cycle, for example on a change of address space. The set count, the number of ways and the field widths are parameters.

Top module: `tlb_sa`

## Requirements
- R1: The set index is `vpn[IDX_W-1:0]` and the tag is the rest of the VPN. A hit needs a valid line in the indexed set whose stored tag equals the lookup tag. A VPN that differs from a stored one only in its index bits misses.
- R2: A lookup presented with `lk_valid` in one cycle is answered in the following cycle. On a hit, `lk_hit` is 1 and `lk_ppn` and `lk_perm` carry the stored values. The permission bits are: bit0 read, bit1 write, bit2 execute, bit3 supervisor-only.
- R3: On a miss, `lk_miss` is 1 and `lk_ppn` and `lk_perm` are zero.
- R4: In a cycle that follows no lookup, both `lk_hit` and `lk_miss` are 0. The two are never 1 together.
- R5: A fill whose tag is not present in its set writes the lowest-numbered invalid way of that set, if the set has one.
- R6: A fill into a set with no invalid way and no matching tag replaces the way named by that set's round-robin pointer. The pointer then advances by one, wrapping from WAYS-1 to 0. The pointer of each set starts at 0 and is independent of the other sets.
- R7: A fill whose tag is already valid in its set overwrites that way. It creates no duplicate and does not move the pointer.
- R8: `inval_all` clears every valid flag in one cycle. A lookup in the same cycle reports a miss, and a fill in the same cycle is dropped. The round-robin pointers are kept.
- R9: A lookup and a fill in the same cycle see the contents as they were before that fill.
- R10: After reset every line is invalid and every pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Previous lookup hit |
| lk_miss | output | 1 | Previous lookup missed |
| lk_ppn | output | PPN_W | Translated physical page number (zero on miss) |
| lk_perm | output | 4 | Permission flags of the hit entry |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | VPN_W | Virtual page number of the new entry |
| fill_ppn | input | PPN_W | Physical page number of the new entry |
| fill_perm | input | 4 | Permission flags of the new entry |
| inval_all | input | 1 | Clear every entry |

## Verification
The bench concentrates its traffic on a few sets and a few tags, so sets fill up and evictions happen often. A victim pointer that is shared between sets, or that advances when a free way was used, would then evict the wrong entry and give hit/miss patterns that differ from the model. Refills of a tag that is already present catch a design that installs duplicates: the old copy would answer with a stale physical page or push out a neighbour. VPNs that differ only in their index bits expose a swapped index/tag split. Fills and invalidates issued in the same cycle as lookups catch a design that forwards new contents or lets a dropped fill survive an invalidate.

// File: rtl/tlb_sa.sv
module tlb_sa #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int VPN_W = 36,
  parameter int PPN_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [3:0]       lk_perm,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [3:0]       fill_perm,
  input  logic             inval_all
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q   [SETS][WAYS];
  logic [3:0]       perm_q  [SETS][WAYS];
  logic [WAY_W-1:0] rr_q    [SETS];

  wire [IDX_W-1:0] l_set = lk_vpn[IDX_W-1:0];
  wire [TAG_W-1:0] l_tag = lk_vpn[VPN_W-1:IDX_W];
  wire [IDX_W-1:0] f_set = fill_vpn[IDX_W-1:0];
  wire [TAG_W-1:0] f_tag = fill_vpn[VPN_W-1:IDX_W];

  logic             hit_any;
  logic [WAY_W-1:0] hit_way;
  logic             match_any, free_any;
  logic [WAY_W-1:0] match_way, free_way, victim;

  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (!hit_any && valid_q[l_set][w] && tag_q[l_set][w] == l_tag) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
  end

  always_comb begin
    match_any = 1'b0;
    match_way = '0;
    free_any  = 1'b0;
    free_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!match_any && valid_q[f_set][w] && tag_q[f_set][w] == f_tag) begin
        match_any = 1'b1;
        match_way = WAY_W'(w);
      end
      if (!free_any && !valid_q[f_set][w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    victim = match_any ? match_way : (free_any ? free_way : rr_q[f_set]);
  end

  wire lk_good = lk_valid && hit_any && !inval_all;
  wire do_fill = fill_en && !inval_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit  <= 1'b0;
      lk_miss <= 1'b0;
      lk_ppn  <= '0;
      lk_perm <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      lk_hit  <= lk_good;
      lk_miss <= lk_valid && !lk_good;
      lk_ppn  <= lk_good ? ppn_q[l_set][hit_way]  : '0;
      lk_perm <= lk_good ? perm_q[l_set][hit_way] : '0;
      if (inval_all) begin
        for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else if (fill_en) begin
        valid_q[f_set][victim] <= 1'b1;
        if (!match_any && !free_any)
          rr_q[f_set] <= (rr_q[f_set] == WAY_W'(WAYS-1)) ? '0 : rr_q[f_set] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[f_set][victim]  <= f_tag;
      ppn_q[f_set][victim]  <= fill_ppn;
      perm_q[f_set][victim] <= fill_perm;
    end
  end

  logic dup_any;
  always_comb begin
    dup_any = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int a = 0; a < WAYS; a++)
        for (int b = a + 1; b < WAYS; b++)
          if (valid_q[s][a] && valid_q[s][b] && tag_q[s][a] == tag_q[s][b])
            dup_any = 1'b1;
  end

  p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n) !dup_any);

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n) !(lk_hit && lk_miss));

  p_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_miss) |-> $past(lk_valid));

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_ppn == '0 && lk_perm == '0));

  p_inval_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inval_all) && $past(rst_n)) |-> !lk_hit);

  p_empty_after_inval_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_all && !fill_en) |=> !hit_any);
endmodule

// File: tb/tlb_sa_test.sv
module tlb_sa_test;
  localparam int SETS = 16, WAYS = 4, VPN_W = 36, PPN_W = 40;
  localparam int IDX_W = 4, TAG_W = VPN_W - IDX_W;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fill_en = 0, inval_all = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0, lk_ppn;
  logic [3:0] fill_perm = '0, lk_perm;
  logic lk_hit, lk_miss;

  always #5 clk = ~clk;

  tlb_sa #(.SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_perm(fill_perm), .inval_all(inval_all));

  int tests = 0, fails = 0;
  bit m_v [SETS][WAYS];
  logic [TAG_W-1:0] m_tag [SETS][WAYS];
  logic [PPN_W-1:0] m_ppn [SETS][WAYS];
  logic [3:0] m_perm [SETS][WAYS];
  int m_rr [SETS];

  function automatic logic [VPN_W-1:0] mk(int tag, int idx);
    return {TAG_W'(tag), IDX_W'(idx)};
  endfunction

  function automatic logic [PPN_W+5:0] model_lookup(logic [VPN_W-1:0] v);
    int s = int'(v[IDX_W-1:0]);
    for (int w = 0; w < WAYS; w++)
      if (m_v[s][w] && m_tag[s][w] == v[VPN_W-1:IDX_W])
        return {1'b1, 1'b0, m_perm[s][w], m_ppn[s][w]};
    return {1'b0, 1'b1, 4'b0, {PPN_W{1'b0}}};
  endfunction

  task automatic model_fill(logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, logic [3:0] pm);
    int s = int'(v[IDX_W-1:0]);
    int way = -1;
    for (int w = 0; w < WAYS; w++)
      if (way < 0 && m_v[s][w] && m_tag[s][w] == v[VPN_W-1:IDX_W]) way = w;
    if (way < 0)
      for (int w = 0; w < WAYS; w++)
        if (way < 0 && !m_v[s][w]) way = w;
    if (way < 0) begin
      way = m_rr[s];
      m_rr[s] = (m_rr[s] + 1) % WAYS;
    end
    m_v[s][way] = 1; m_tag[s][way] = v[VPN_W-1:IDX_W];
    m_ppn[s][way] = p; m_perm[s][way] = pm;
  endtask

  task automatic check(string req, logic [PPN_W+5:0] act, logic [PPN_W+5:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got hit=%b miss=%b perm=%h ppn=%h, expected hit=%b miss=%b perm=%h ppn=%h",
        req, act[PPN_W+5], act[PPN_W+4], act[PPN_W+3:PPN_W], act[PPN_W-1:0],
        exp[PPN_W+5], exp[PPN_W+4], exp[PPN_W+3:PPN_W], exp[PPN_W-1:0]);
    end
  endtask

  // One cycle: drive, update model, then compare the answer after the edge.
  task automatic step(string req, bit lv, logic [VPN_W-1:0] lvpn, bit fe,
                      logic [VPN_W-1:0] fv, logic [PPN_W-1:0] fp, logic [3:0] fpm, bit inv);
    logic [PPN_W+5:0] exp;
    lk_valid = lv; lk_vpn = lvpn; fill_en = fe; fill_vpn = fv;
    fill_ppn = fp; fill_perm = fpm; inval_all = inv;
    exp = lv ? model_lookup(lvpn) : '0;
    if (lv && inv) exp = {1'b0, 1'b1, 4'b0, {PPN_W{1'b0}}};
    if (inv) begin
      for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
    end else if (fe) model_fill(fv, fp, fpm);
    @(posedge clk); #2;
    check(req, {lk_hit, lk_miss, lk_perm, lk_ppn}, exp);
    lk_valid = 0; fill_en = 0; inval_all = 0;
  endtask

  task automatic look(string req, logic [VPN_W-1:0] v);
    step(req, 1, v, 0, '0, '0, '0, 0);
  endtask

  task automatic fill(string req, logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, logic [3:0] pm);
    step(req, 0, '0, 1, v, p, pm, 0);
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tests++;
    if (lk_hit !== 0 || lk_miss !== 0) begin
      fails++; $display("FAIL R10: got hit=%b miss=%b, expected 0 0", lk_hit, lk_miss);
    end
    look("R10 empty after reset", mk(7, 3));
    look("R10 empty after reset", mk(0, 0));
    step("R4 idle cycle", 0, mk(7, 3), 0, '0, '0, '0, 0);

    fill("R2 fill", mk(7, 3), 40'hAB_CDEF_0123, 4'b1011);
    look("R2 hit data and perm", mk(7, 3));
    look("R1 index differs only", mk(7, 4));
    look("R3 tag differs", mk(8, 3));

    // R5/R6: fill set 5 beyond capacity; oldest must go first
    for (int t = 1; t <= 4; t++) fill("R5 fill free way", mk(t, 5), PPN_W'(t * 16), 4'(t));
    for (int t = 1; t <= 4; t++) look("R5 all resident", mk(t, 5));
    fill("R6 evict rr way0", mk(9, 5), 40'h99, 4'h9);
    look("R6 victim gone", mk(1, 5));
    look("R6 others stay", mk(2, 5));
    fill("R6 evict rr way1", mk(10, 5), 40'hA0, 4'hA);
    look("R6 second victim gone", mk(2, 5));
    look("R6 third stays", mk(3, 5));

    // R7: refill of a present tag replaces in place
    fill("R7 refill", mk(9, 5), 40'h1234, 4'h6);
    look("R7 new value", mk(9, 5));
    look("R7 neighbour kept", mk(3, 5));
    look("R7 neighbour kept", mk(4, 5));

    // R9: lookup and fill in the same cycle
    step("R9 same-cycle fill not visible", 1, mk(20, 9), 1, mk(20, 9), 40'h55, 4'h1, 0);
    look("R9 visible next", mk(20, 9));

    // R8: invalidate with lookup and fill in the same cycle
    step("R8 lookup during inval", 1, mk(20, 9), 1, mk(21, 9), 40'h66, 4'h2, 1);
    look("R8 cleared", mk(20, 9));
    look("R8 fill dropped", mk(21, 9));
    look("R8 cleared", mk(7, 3));

    // R6 pointer kept across invalidate: set 5 pointer is now 2
    for (int t = 30; t < 34; t++) fill("R8 refill set", mk(t, 5), PPN_W'(t), 4'h3);
    fill("R6 rr after inval", mk(40, 5), 40'h400, 4'h4);
    look("R6 rr victim way2", mk(32, 5));
    look("R6 way0 kept", mk(30, 5));

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [VPN_W-1:0] a = mk($urandom_range(0, 7), $urandom_range(0, 3));
      logic [VPN_W-1:0] b = mk($urandom_range(0, 7), $urandom_range(0, 3));
      step("R1 R5 R6 R7 R9 random", r < 70, a, r >= 40, b,
           {$urandom, 8'($urandom)}, 4'($urandom), r == 99);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule